// File: doc/BRIEF.md
# PSRAM Host Interface Controller

This block sits inside a synchronous design and drives an asynchronous pseudo-static RAM with a 17-bit address and an 8-bit data path. Every timing figure of the memory is converted into a clock-cycle count and given as a parameter. The RAM takes its address on the falling edge of chip-enable, so each access is one complete enable-low window followed by a precharge gap. The controller produces all memory strobes from registers, so they are glitch-free. It splits the bidirectional data bus into an output value, a driver enable and an input value.

Users issue requests on a valid/ready port. A request is accepted in the cycle where `req_valid` and `req_ready` are both high. Until that cycle, `req_valid` and the payload must stay stable. `req_ready` is low while the power-up sequence runs, while a refresh is pending or running, and while an access is under way. A requester therefore stalls there, and requests are served strictly in acceptance order. Read and read-modify-write return one byte on `rsp_valid`/`rsp_rdata`. That response port is a one-cycle pulse and has no back-pressure. A write returns nothing.

After reset the controller holds the memory idle for the initialization pause and then runs a fixed number of dummy enable pulses. Only after these does it accept traffic. A free-running interval timer raises a refresh request. The controller serves it between user accesses with a refresh-pin pulse while chip-enable is high.

Top module: `psram_ctrl`

## Requirements
- R1: After reset, enable and refresh stay inactive (high) for at least INIT_PAUSE_CYC cycles. Then exactly DUMMY_CNT enable pulses run with output-enable and write strobe both high. `req_ready` stays low until those pulses are finished.
- R2: A request is taken only when valid and ready are both high, and ready is low while enable is low. `req_op` codes are 0 = read, 1 = write, 2 = read-modify-write, and 3 is served as a read. Responses come back in acceptance order.
- R3: Enable stays low for exactly CE_LOW_CYC cycles for a read or write, and exactly RMW_CYC cycles for a read-modify-write. After that it stays high for at least PRE_CYC cycles before the next falling edge.
- R4: `mem_addr` is valid before enable falls and stays stable for the whole low window. Chip-select is high whenever enable is low.
- R5: For a read, output-enable is low and the write strobe is high for the whole low window. The data sampled in the last low cycle appears on `rsp_rdata`, with a one-cycle `rsp_valid` pulse, in the cycle after enable rises.
- R6: For a write, the data driver is on for the whole low window and output-enable stays high. The write strobe is low in all but the last low cycle, so the memory latches the data on the rising strobe while the data is still driven.
- R7: A read-modify-write reads during its first CE_LOW_CYC low cycles, then leaves one turnaround cycle with neither output-enable nor the driver on, then writes. It returns the old byte and stores the new one.
- R8: The data driver is never enabled while output-enable is low.
- R9: A refresh request is raised every REFRESH_CYC cycles and wins over a waiting user request. The refresh pin goes low for RF_PULSE_CYC cycles only while enable is high. Before the pulse, enable has been high for at least RF_DELAY_CYC cycles. After the pulse, at least RF_PRE_CYC cycles pass before enable falls again. Ready is low during refresh.
- R10: A write produces no response pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 2 | 0 read, 1 write, 2 read-modify-write, 3 read |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | DW | Read data |
| mem_addr | output | AW | Memory address bus |
| mem_en_n | output | 1 | Chip-enable, active low |
| mem_sel | output | 1 | Chip-select, active high |
| mem_rd_en_n | output | 1 | Output-enable, active low |
| mem_wr_n | output | 1 | Read/write strobe, low writes |
| mem_refresh_n | output | 1 | Refresh pin, active low |
| mem_dq_out | output | DW | Data toward the memory |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_in | input | DW | Data from the memory |

## Verification
The bench builds the block with AW=10, a 4-cycle access window, a 9-cycle read-modify-write window, 3 precharge cycles, a 25-cycle pause and a 150-cycle refresh interval. With these values a full power-up sequence plus dozens of refreshes fit into a few thousand cycles, so refreshes collide with queued requests many times. The 1 KiB address space lets the stub memory be compared in full against the bench model at the end. The minimal RMW window (read, turnaround, write) is also close enough that an off-by-one in the phase boundaries causes bus contention or corrupt data.

// File: rtl/psram_pkg.sv
package psram_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_RMW   = 2'd2,
    OP_SPARE = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    ST_PAUSE, ST_DLOW, ST_DPRE, ST_IDLE, ST_LOW, ST_PRE,
    ST_RDLY, ST_RPUL, ST_RPRE
  } st_e;

  typedef struct packed {
    logic en_n;
    logic sel;
    logic rd_en_n;
    logic wr_n;
    logic refresh_n;
    logic drive;
    logic capture;
  } pins_t;

  localparam pins_t PINS_IDLE = '{en_n: 1'b1, sel: 1'b0, rd_en_n: 1'b1,
                                  wr_n: 1'b1, refresh_n: 1'b1, drive: 1'b0,
                                  capture: 1'b0};

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/psram_refresh_timer.sv
module psram_refresh_timer #(
  parameter int REFRESH_CYC = 3900
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic pend
);
  localparam int TW = $clog2(REFRESH_CYC + 1);
  localparam logic [TW-1:0] T_LAST = TW'(REFRESH_CYC - 1);

  logic [TW-1:0] cnt_q;
  logic          wrap;

  assign wrap = (cnt_q == T_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pend  <= 1'b0;
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      if (wrap)     pend <= 1'b1;
      else if (ack) pend <= 1'b0;
    end
  end

  // R9: a raised refresh request is kept until it is served
  assert_pend_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !ack) |=> pend);

endmodule

// File: rtl/psram_seq.sv
module psram_seq
  import psram_pkg::*;
#(
  parameter int AW             = 17,
  parameter int DW             = 8,
  parameter int INIT_PAUSE_CYC = 25000,
  parameter int DUMMY_CNT      = 8,
  parameter int CE_LOW_CYC     = 16,
  parameter int RMW_CYC        = 32,
  parameter int PRE_CYC        = 11,
  parameter int RF_DELAY_CYC   = 9,
  parameter int RF_PULSE_CYC   = 8,
  parameter int RF_PRE_CYC     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          rf_pend,
  output logic          rf_ack,
  output pins_t         pins_d,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q
);
  localparam int MAXC = max2(max2(max2(INIT_PAUSE_CYC, RMW_CYC), max2(PRE_CYC, RF_DELAY_CYC)),
                             max2(max2(RF_PULSE_CYC, RF_PRE_CYC), CE_LOW_CYC));
  localparam int CW   = $clog2(MAXC + 1);
  localparam int DCW  = $clog2(DUMMY_CNT + 1);
  localparam logic [CW-1:0]  T_PAUSE = CW'(INIT_PAUSE_CYC - 1);
  localparam logic [CW-1:0]  T_LOW   = CW'(CE_LOW_CYC - 1);
  localparam logic [CW-1:0]  T_TURN  = CW'(CE_LOW_CYC);
  localparam logic [CW-1:0]  T_RMW   = CW'(RMW_CYC - 1);
  localparam logic [CW-1:0]  T_PRE   = CW'(PRE_CYC - 1);
  localparam logic [CW-1:0]  T_RDLY  = CW'(RF_DELAY_CYC - 1);
  localparam logic [CW-1:0]  T_RPUL  = CW'(RF_PULSE_CYC - 1);
  localparam logic [CW-1:0]  T_RPRE  = CW'(RF_PRE_CYC - 1);
  localparam logic [DCW-1:0] D_LAST  = DCW'(DUMMY_CNT - 1);

  st_e            st_q, st_n;
  logic [CW-1:0]  cnt_q;
  logic [DCW-1:0] dum_q;
  op_e            op_q;
  logic           accept;
  logic           cnt_clr;
  logic [CW-1:0]  len_last;

  assign len_last  = (op_q == OP_RMW) ? T_RMW : T_LOW;
  assign req_ready = (st_q == ST_IDLE) && !rf_pend;

  always_comb begin
    st_n   = st_q;
    rf_ack = 1'b0;
    accept = 1'b0;
    unique case (st_q)
      ST_PAUSE: if (cnt_q == T_PAUSE) st_n = ST_DLOW;
      ST_DLOW:  if (cnt_q == T_LOW)   st_n = ST_DPRE;
      ST_DPRE:  if (cnt_q == T_PRE)   st_n = (dum_q == D_LAST) ? ST_IDLE : ST_DLOW;
      ST_IDLE: begin
        if (rf_pend) begin
          st_n   = ST_RDLY;
          rf_ack = 1'b1;
        end else if (req_valid) begin
          st_n   = ST_LOW;
          accept = 1'b1;
        end
      end
      ST_LOW:   if (cnt_q == len_last) st_n = ST_PRE;
      ST_PRE:   if (cnt_q == T_PRE)    st_n = ST_IDLE;
      ST_RDLY:  if (cnt_q == T_RDLY)   st_n = ST_RPUL;
      ST_RPUL:  if (cnt_q == T_RPUL)   st_n = ST_RPRE;
      ST_RPRE:  if (cnt_q == T_RPRE)   st_n = ST_IDLE;
      default:  st_n = ST_IDLE;
    endcase
  end

  assign cnt_clr = (st_n != st_q) || (st_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_PAUSE;
      cnt_q   <= '0;
      dum_q   <= '0;
      op_q    <= OP_READ;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_clr ? '0 : cnt_q + 1'b1;
      if (st_q == ST_DPRE && st_n == ST_DLOW) dum_q <= dum_q + 1'b1;
      if (accept) begin
        op_q    <= (op_e'(req_op) == OP_SPARE) ? OP_READ : op_e'(req_op);
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
    end
  end

  // Strobe decode; registered one stage later in the io block
  always_comb begin
    pins_d = PINS_IDLE;
    unique case (st_q)
      ST_DLOW: begin
        pins_d.en_n = 1'b0;
        pins_d.sel  = 1'b1;
      end
      ST_LOW: begin
        pins_d.en_n = 1'b0;
        pins_d.sel  = 1'b1;
        unique case (op_q)
          OP_WRITE: begin
            pins_d.drive = 1'b1;
            pins_d.wr_n  = (cnt_q == T_LOW);
          end
          OP_RMW: begin
            pins_d.rd_en_n = (cnt_q > T_LOW);
            pins_d.capture = (cnt_q == T_LOW);
            pins_d.drive   = (cnt_q > T_TURN);
            pins_d.wr_n    = !((cnt_q > T_TURN) && (cnt_q != T_RMW));
          end
          default: begin
            pins_d.rd_en_n = 1'b0;
            pins_d.capture = (cnt_q == T_LOW);
          end
        endcase
      end
      ST_RPUL: pins_d.refresh_n = 1'b0;
      default: pins_d = PINS_IDLE;
    endcase
  end

  // R1: traffic only after every dummy pulse has run
  assert_ready_after_dummies_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (dum_q == D_LAST));

  // R9: a pending refresh is served before any waiting request
  assert_refresh_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && rf_pend) |=> (st_q == ST_RDLY));

  // R2: an accepted request starts an access with its own address
  assert_accept_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (st_q == ST_LOW && addr_q == $past(req_addr)));

endmodule

// File: rtl/psram_io.sv
module psram_io
  import psram_pkg::*;
#(
  parameter int DW         = 8,
  parameter int CE_LOW_CYC = 16,
  parameter int RMW_CYC    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pins_t         pins_d,
  input  logic [DW-1:0] dq_in,
  output logic          en_n,
  output logic          sel,
  output logic          rd_en_n,
  output logic          wr_n,
  output logic          refresh_n,
  output logic          drive,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);
  localparam int LW = $clog2(RMW_CYC + 2);

  pins_t         pins_q;
  logic [LW-1:0] low_run;

  assign en_n      = pins_q.en_n;
  assign sel       = pins_q.sel;
  assign rd_en_n   = pins_q.rd_en_n;
  assign wr_n      = pins_q.wr_n;
  assign refresh_n = pins_q.refresh_n;
  assign drive     = pins_q.drive;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pins_q    <= PINS_IDLE;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      low_run   <= '0;
    end else begin
      pins_q    <= pins_d;
      rsp_valid <= pins_q.capture;
      if (pins_q.capture) rsp_rdata <= dq_in;
      low_run   <= pins_q.en_n ? '0 : low_run + 1'b1;
    end
  end

  // R9: the refresh pin is only pulsed while enable is high
  assert_refresh_en_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pins_q.refresh_n |-> pins_q.en_n);

  // R8: driver and memory output are never on together
  assert_no_bus_fight_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pins_q.drive |-> pins_q.rd_en_n);

  // R3: each enable pulse has one of the two legal lengths
  assert_en_low_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pins_q.en_n) |-> (low_run == LW'(CE_LOW_CYC) || low_run == LW'(RMW_CYC)));

endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
  import psram_pkg::*;
#(
  parameter int AW             = 17,
  parameter int DW             = 8,
  parameter int INIT_PAUSE_CYC = 25000,
  parameter int DUMMY_CNT      = 8,
  parameter int CE_LOW_CYC     = 16,
  parameter int RMW_CYC        = 32,
  parameter int PRE_CYC        = 11,
  parameter int REFRESH_CYC    = 3900,
  parameter int RF_DELAY_CYC   = 9,
  parameter int RF_PULSE_CYC   = 8,
  parameter int RF_PRE_CYC     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_en_n,
  output logic          mem_sel,
  output logic          mem_rd_en_n,
  output logic          mem_wr_n,
  output logic          mem_refresh_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  pins_t pins_d;
  logic  rf_pend, rf_ack;

  psram_refresh_timer #(.REFRESH_CYC(REFRESH_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .ack(rf_ack), .pend(rf_pend)
  );

  psram_seq #(
    .AW(AW), .DW(DW), .INIT_PAUSE_CYC(INIT_PAUSE_CYC), .DUMMY_CNT(DUMMY_CNT),
    .CE_LOW_CYC(CE_LOW_CYC), .RMW_CYC(RMW_CYC), .PRE_CYC(PRE_CYC),
    .RF_DELAY_CYC(RF_DELAY_CYC), .RF_PULSE_CYC(RF_PULSE_CYC), .RF_PRE_CYC(RF_PRE_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rf_pend(rf_pend), .rf_ack(rf_ack), .pins_d(pins_d),
    .addr_q(mem_addr), .wdata_q(mem_dq_out)
  );

  psram_io #(.DW(DW), .CE_LOW_CYC(CE_LOW_CYC), .RMW_CYC(RMW_CYC)) u_io (
    .clk(clk), .rst_n(rst_n), .pins_d(pins_d), .dq_in(mem_dq_in),
    .en_n(mem_en_n), .sel(mem_sel), .rd_en_n(mem_rd_en_n), .wr_n(mem_wr_n),
    .refresh_n(mem_refresh_n), .drive(mem_dq_oe),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  // R4: address held steady through the whole enable-low window
  assert_addr_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_en_n && $past(!mem_en_n)) |-> $stable(mem_addr));

  // R2: no request is taken while an access holds enable low
  assert_no_ready_in_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_en_n |-> !req_ready);

endmodule

// File: tb/psram_ctrl_bench.sv
module psram_ctrl_bench;
  localparam int AW = 10, DW = 8;
  localparam int P_PAUSE = 25, P_DUMMY = 8, P_LOW = 4, P_RMW = 9, P_PRE = 3;
  localparam int P_REF = 150, P_RDLY = 2, P_RPUL = 3, P_RPRE = 2;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic mem_en_n, mem_sel, mem_rd_en_n, mem_wr_n, mem_refresh_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_out, mem_dq_in;

  always #2 clk = ~clk;

  psram_ctrl #(
    .AW(AW), .DW(DW), .INIT_PAUSE_CYC(P_PAUSE), .DUMMY_CNT(P_DUMMY),
    .CE_LOW_CYC(P_LOW), .RMW_CYC(P_RMW), .PRE_CYC(P_PRE), .REFRESH_CYC(P_REF),
    .RF_DELAY_CYC(P_RDLY), .RF_PULSE_CYC(P_RPUL), .RF_PRE_CYC(P_RPRE)
  ) u_psram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_en_n(mem_en_n), .mem_sel(mem_sel), .mem_rd_en_n(mem_rd_en_n),
    .mem_wr_n(mem_wr_n), .mem_refresh_n(mem_refresh_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // Behavioural memory stub with timing monitor
  logic [DW-1:0] smem [DEPTH];
  logic [DW-1:0] emem [DEPTH];
  logic [AW-1:0] lat_addr = '0;
  logic stub_drv;
  assign stub_drv  = !mem_en_n && !mem_rd_en_n;
  assign mem_dq_in = stub_drv ? smem[lat_addr] : 8'h00;

  int low_run = 0, high_run = 0, rf_low = 0, rf_gap = 0, since_rf = 1000;
  int falls = 0, rf_seen = 0;
  bit prev_en = 1, prev_rf = 1, seen_ready = 0;
  bit addr_ok = 1, bus_ok = 1, wr_ok = 1, saw_rd = 0, saw_wr = 0, rf_ok = 1;
  bit init_ok = 1, ready_ok = 1;

  always @(negedge clk) if (rst_n) begin
    if (mem_dq_oe && stub_drv) bus_ok = 0;
    if (mem_dq_oe && !mem_rd_en_n) bus_ok = 0;
    if (!mem_refresh_n && !mem_en_n) rf_ok = 0;
    if (req_ready && (!mem_refresh_n || !mem_en_n)) ready_ok = 0;
    if (!seen_ready && (!mem_rd_en_n || !mem_wr_n)) init_ok = 0;
    if (req_ready && !seen_ready) begin
      seen_ready = 1;
      chk(falls == P_DUMMY, "R1 dummy pulses before ready", falls, P_DUMMY);
      chk(init_ok, "R1 strobes quiet during init", 0, 1);
    end
    if (prev_en && !mem_en_n) begin
      if (falls == 0) chk(high_run >= P_PAUSE, "R1 pause", high_run, P_PAUSE);
      else chk(high_run >= P_PRE, "R3 precharge", high_run, P_PRE);
      if (rf_seen > 0) chk(since_rf >= P_RPRE, "R9 refresh precharge", since_rf, P_RPRE);
      falls++;
      lat_addr = mem_addr;
      addr_ok = 1; wr_ok = 1; saw_rd = 0; saw_wr = 0;
      low_run = 0; high_run = 0;
    end
    if (!prev_en && mem_en_n) begin
      chk(low_run == P_LOW || low_run == P_RMW, "R3 enable low length", low_run, P_LOW);
      chk(addr_ok, "R4 address/select during low", 0, 1);
      chk(bus_ok, "R8 bus ownership", 0, 1);
      chk(wr_ok, "R6 write strobe framing", 0, 1);
      if (low_run == P_RMW) chk(saw_rd && saw_wr, "R7 rmw phases", {saw_rd, saw_wr}, 3);
    end
    if (!mem_en_n) begin
      low_run++;
      if (mem_addr != lat_addr || !mem_sel) addr_ok = 0;
      if (!mem_rd_en_n) saw_rd = 1;
      if (!mem_wr_n) begin
        saw_wr = 1;
        if (!mem_dq_oe || !mem_rd_en_n) wr_ok = 0;
        smem[lat_addr] = mem_dq_out;
      end
    end else high_run++;
    if (prev_rf && !mem_refresh_n) begin
      chk(high_run >= P_RDLY, "R9 delay before refresh", high_run, P_RDLY);
      if (rf_seen > 0) chk(rf_gap <= P_REF + 20, "R9 refresh interval", rf_gap, P_REF);
      rf_seen++; rf_gap = 0; rf_low = 0;
    end
    if (!prev_rf && mem_refresh_n) begin
      chk(rf_low == P_RPUL && rf_ok, "R9 refresh pulse", rf_low, P_RPUL);
      since_rf = 0;
    end
    if (!mem_refresh_n) rf_low++;
    rf_gap++; since_rf++;
    prev_en = mem_en_n; prev_rf = mem_refresh_n;
  end

  // Expected responses
  logic [DW-1:0] expq[$];
  string tagq[$];
  int rsp_seen = 0;

  always @(negedge clk) if (rst_n && rsp_valid) begin
    rsp_seen++;
    if (expq.size() == 0) chk(0, "R10 unexpected response", 1, 0);
    else begin
      logic [DW-1:0] e;
      string t;
      e = expq.pop_front();
      t = tagq.pop_front();
      chk(rsp_rdata == e, t, rsp_rdata, e);
    end
  end

  function automatic logic [DW-1:0] model_rd(input logic [AW-1:0] a);
    return emem[a];
  endfunction

  task automatic do_req(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    case (op)
      2'd1: emem[a] = d;
      2'd2: begin expq.push_back(model_rd(a)); tagq.push_back("R7 rmw old data"); emem[a] = d; end
      2'd3: begin expq.push_back(model_rd(a)); tagq.push_back("R2 spare code as read"); end
      default: begin expq.push_back(model_rd(a)); tagq.push_back("R5 read data"); end
    endcase
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int mism;
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) begin smem[i] = '0; emem[i] = '0; end
    repeat (4) @(negedge clk);
    chk(mem_en_n && mem_refresh_n && !req_ready && !mem_dq_oe && !rsp_valid,
        "R1 reset state", {mem_en_n, mem_refresh_n, req_ready, mem_dq_oe}, 4'b1100);
    rst_n = 1;
    // directed corners
    do_req(2'd1, '0, 8'h5A);
    do_req(2'd1, '1, 8'hC3);
    do_req(2'd0, '0, 8'h00);
    do_req(2'd0, '1, 8'h00);
    do_req(2'd2, '0, 8'h11);
    do_req(2'd0, '0, 8'h00);
    do_req(2'd3, '1, 8'h00);
    do_req(2'd2, '1, 8'h77);
    do_req(2'd2, '1, 8'h88);
    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [1:0] op;
      logic [AW-1:0] a;
      op = 2'($urandom_range(0, 3));
      a  = (i % 5 == 0) ? AW'($urandom_range(0, 7)) : AW'($urandom);
      do_req(op, a, 8'($urandom));
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end
    repeat (40) @(negedge clk);
    chk(rsp_valid == 0, "R10 no trailing response", rsp_valid, 0);
    chk(expq.size() == 0, "R10 all responses delivered", expq.size(), 0);
    chk(ready_ok, "R2 ready low in access and refresh", 0, 1);
    chk(rf_seen > 10, "R9 refreshes issued", rf_seen, 11);
    mism = 0;
    for (int i = 0; i < DEPTH; i++) if (smem[i] !== emem[i]) mism++;
    chk(mism == 0, "R6 memory contents after writes", mism, 0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule